// File: doc/BRIEF.md
# Search-Engine SRAM Write Command Pipeline

This block lives inside a content-search coprocessor. It watches the host command port for a write aimed at the associated result SRAM. When a write arrives for this device, the block rebuilds the 24-bit SRAM address and sends out a single SRAM write strobe cycle after a fixed, parameterised pipeline delay. That delay matches the latency of a search, so the SRAM write slots into the same pipeline timing as search results.

The clock is the double-rate clock. Each command cycle therefore spans two consecutive clocks, called phase A and phase B. A write occupies the host port for three command cycles:

- Command cycle 1 is the address cycle (phases A and B).
- Command cycles 2 and 3 are four filler clocks. The host keeps driving the bus during them, but the block ignores it.

A new command may start on the clock after the fillers. The write travels through a shift pipeline, so writes spaced at that minimum pitch are never stalled. A device whose ID does not match the command, or a command that is not a plain single SRAM write, leaves every SRAM strobe inactive.

Top module: `srch_sram_wr_pipe`

## Requirements
- R1: While `rst` is high, and on the first clock after it falls, `sram_ce_n`, `sram_we_n`, `sram_oe_n` and `sram_ale_n` are 1 and `sram_adr` is 0.
- R2: A write needs `cmd_vld`=1 and `cmd_op`=2'b01 on the phase-A clock and again on the next clock (phase B). If phase B does not repeat the write opcode, no SRAM cycle is produced.
- R3: An SRAM cycle is produced only when `dq[20:19]` equals 2'b10 on the phase-A clock.
- R4: An SRAM cycle is produced only when `dq[25:21]` equals `dev_id` on the phase-A clock.
- R5: `cmd_ext[0]` carries the burst flag (command bit 2). If it is 1 on the phase-A clock, no SRAM cycle is produced.
- R6: The emitted address takes bits [23:21] from `cmd_ext[6:4]` and bits [20:0] from `dq[46:26]`, all sampled on the phase-A clock.
- R7: During the four clocks after phase B, `cmd_vld`, `cmd_op`, `cmd_ext` and `dq` are ignored, even when they look like a valid write.
- R8: Let the phase-A sample be taken at rising edge k. After edge k+1+LAT, `sram_ce_n`, `sram_we_n` and `sram_ale_n` are 0 for exactly one clock, `sram_oe_n` stays 1, and `sram_adr` holds the address.
- R9: At all other times the four strobes are 1 and `sram_adr` is 0.
- R10: Writes whose phase-A clocks are six clocks apart each produce their SRAM cycle, in issue order, with no write lost or stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; one clock per command phase |
| rst | input | 1 | Synchronous active-high reset |
| cmd_vld | input | 1 | Command-valid strobe |
| cmd_op | input | 2 | Command opcode; 2'b01 is write |
| cmd_ext | input | 9 | Upper command bits; [0] burst flag, [6:4] SRAM address [23:21] |
| dq | input | 72 | Host data/address bus |
| dev_id | input | 5 | This device's ID in the table |
| sram_adr | output | 24 | SRAM address, 0 when idle |
| sram_ce_n | output | 1 | SRAM chip enable, active low |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low, held high |
| sram_ale_n | output | 1 | SRAM address-latch strobe, active low |

## Verification
The assertions check the following on every clock:

- Every accepted write was backed by a write opcode, an SRAM target, a matching ID and a clear burst flag on the phase-A sample.
- The write-enable pulse never lasts longer than one clock.

The exact emission delay, the address assembly, the filler clocks being ignored and the ordering of back-to-back writes are shown only by the bench. Its queue-based model compares all outputs on every clock while the scenarios go through rejects, dropped phase-B opcodes and fillers that carry write-like garbage.

// File: rtl/sw_pkg.sv
package sw_pkg;
  localparam int DQ_W    = 72;
  localparam int ADR_W   = 24;
  localparam int ID_W    = 5;
  localparam int EXT_W   = 9;
  localparam int FILL_CLKS = 4;

  localparam logic [1:0] OP_WR    = 2'b01;
  localparam logic [1:0] TGT_SRAM = 2'b10;

  localparam int TGT_LO  = 19;
  localparam int ID_LO   = 21;
  localparam int ALO_LO  = 26;
  localparam int ALO_W   = 21;
  localparam int AHI_LO  = 4;
  localparam int BURST_B = 0;

  typedef enum logic [1:0] {ST_IDLE, ST_GOT_A, ST_FILL} dec_st_e;

  typedef struct packed {
    logic             vld;
    logic [ADR_W-1:0] adr;
  } wr_req_t;
endpackage

// File: rtl/sw_cmd_dec.sv
module sw_cmd_dec
  import sw_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [EXT_W-1:0]  cmd_ext,
  input  logic [DQ_W-1:0]   dq,
  input  logic [ID_W-1:0]   dev_id,
  output wr_req_t           req
);
  localparam int CW = $clog2(FILL_CLKS + 1);

  dec_st_e          st;
  logic [CW-1:0]    fill_cnt;
  logic             cap_ok;
  logic [ADR_W-1:0] cap_adr;
  logic             wr_seen;

  assign wr_seen = cmd_vld && (cmd_op == OP_WR);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      fill_cnt <= '0;
      cap_ok   <= 1'b0;
      cap_adr  <= '0;
    end else begin
      case (st)
        ST_IDLE: if (wr_seen) begin
          st      <= ST_GOT_A;
          cap_ok  <= (dq[TGT_LO +: 2] == TGT_SRAM) &&
                     (dq[ID_LO +: ID_W] == dev_id) &&
                     !cmd_ext[BURST_B];
          cap_adr <= {cmd_ext[AHI_LO +: 3], dq[ALO_LO +: ALO_W]};
        end
        ST_GOT_A: begin
          st       <= ST_FILL;
          fill_cnt <= '0;
        end
        ST_FILL: begin
          if (fill_cnt == CW'(FILL_CLKS - 1)) st <= ST_IDLE;
          else fill_cnt <= fill_cnt + 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req.vld = (st == ST_GOT_A) && wr_seen && cap_ok;
    req.adr = cap_adr;
  end

  AST_ISSUE_NEEDS_A: assert property (@(posedge clk) disable iff (rst)
    req.vld |-> $past(cmd_vld && cmd_op == OP_WR)); // R2
  AST_ISSUE_TARGET: assert property (@(posedge clk) disable iff (rst)
    req.vld |-> $past(dq[TGT_LO +: 2]) == TGT_SRAM); // R3
  AST_ISSUE_ID: assert property (@(posedge clk) disable iff (rst)
    req.vld |-> $past(dq[ID_LO +: ID_W]) == $past(dev_id)); // R4
  AST_ISSUE_NOBURST: assert property (@(posedge clk) disable iff (rst)
    req.vld |-> !$past(cmd_ext[BURST_B])); // R5
endmodule

// File: rtl/sw_delay_line.sv
module sw_delay_line
  import sw_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic    clk,
  input  logic    rst,
  input  wr_req_t din,
  output wr_req_t dout
);
  wr_req_t stg [LAT];

  for (genvar i = 0; i < LAT; i++) begin : g_stg
    always_ff @(posedge clk) begin
      if (rst) stg[i] <= '0;
      else if (i == 0) stg[i] <= din;
      else stg[i] <= stg[(i == 0) ? 0 : i-1];
    end
  end

  assign dout = stg[LAT-1];
endmodule

// File: rtl/sw_sram_drv.sv
module sw_sram_drv
  import sw_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  wr_req_t          req,
  output logic [ADR_W-1:0] sram_adr,
  output logic             sram_ce_n,
  output logic             sram_we_n,
  output logic             sram_oe_n,
  output logic             sram_ale_n
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sram_adr   <= '0;
      sram_ce_n  <= 1'b1;
      sram_we_n  <= 1'b1;
      sram_oe_n  <= 1'b1;
      sram_ale_n <= 1'b1;
    end else begin
      sram_adr   <= req.vld ? req.adr : '0;
      sram_ce_n  <= !req.vld;
      sram_we_n  <= !req.vld;
      sram_oe_n  <= 1'b1;
      sram_ale_n <= !req.vld;
    end
  end

  AST_WE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |=> sram_we_n); // R8
endmodule

// File: rtl/srch_sram_wr_pipe.sv
module srch_sram_wr_pipe
  import sw_pkg::*;
#(
  parameter int LAT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_vld,
  input  logic [1:0]        cmd_op,
  input  logic [EXT_W-1:0]  cmd_ext,
  input  logic [DQ_W-1:0]   dq,
  input  logic [ID_W-1:0]   dev_id,
  output logic [ADR_W-1:0]  sram_adr,
  output logic              sram_ce_n,
  output logic              sram_we_n,
  output logic              sram_oe_n,
  output logic              sram_ale_n
);
  wr_req_t dec_req, dly_req;

  sw_cmd_dec u_dec (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ext(cmd_ext), .dq(dq), .dev_id(dev_id), .req(dec_req)
  );

  sw_delay_line #(.LAT(LAT)) u_dly (
    .clk(clk), .rst(rst), .din(dec_req), .dout(dly_req)
  );

  sw_sram_drv u_drv (
    .clk(clk), .rst(rst), .req(dly_req), .sram_adr(sram_adr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ale_n(sram_ale_n)
  );

  AST_IDLE_ADR: assert property (@(posedge clk) disable iff (rst)
    sram_ce_n |-> (sram_adr == '0) && sram_we_n && sram_ale_n); // R9
endmodule

// File: tb/tb_srch_sram_wr_pipe.sv
module tb_srch_sram_wr_pipe;
  localparam int LAT = 4;
  localparam logic [4:0] MY_ID = 5'd7;

  typedef struct {
    int          due;
    logic [23:0] adr;
    string       tag;
  } exp_t;

  logic        clk = 0, rst = 1;
  logic        cmd_vld = 0;
  logic [1:0]  cmd_op = 0;
  logic [8:0]  cmd_ext = 0;
  logic [71:0] dq = 0;
  logic [23:0] sram_adr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ale_n;

  int cyc = 0, checks = 0, errors = 0;
  exp_t q[$];

  srch_sram_wr_pipe #(.LAT(LAT)) dut (
    .clk(clk), .rst(rst), .cmd_vld(cmd_vld), .cmd_op(cmd_op),
    .cmd_ext(cmd_ext), .dq(dq), .dev_id(MY_ID), .sram_adr(sram_adr),
    .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ale_n(sram_ale_n)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [71:0] rnd72();
    return {$urandom, $urandom, $urandom};
  endfunction

  task automatic cmp(input string tag, input logic [27:0] act, input logic [27:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s cyc %0d act ce/we/oe/ale/adr=%h exp=%h", tag, cyc, act, exp);
    end
  endtask

  // per-clock reference comparison
  always @(negedge clk) begin
    if (rst) begin
      cmp("R1", {sram_ce_n, sram_we_n, sram_oe_n, sram_ale_n, sram_adr}, {4'hF, 24'h0});
    end else begin
      if (q.size() > 0 && q[0].due == cyc) begin
        cmp(q[0].tag, {sram_ce_n, sram_we_n, sram_oe_n, sram_ale_n, sram_adr},
            {4'b0010, q[0].adr});
        void'(q.pop_front());
      end else begin
        cmp("R9", {sram_ce_n, sram_we_n, sram_oe_n, sram_ale_n, sram_adr}, {4'hF, 24'h0});
        if (q.size() > 0 && q[0].due < cyc) void'(q.pop_front());
      end
    end
  end

  // phase A, phase B, then four filler clocks that look like writes (R7)
  task automatic send(input bit hold_b, input logic [1:0] tgt, input logic [4:0] id,
                      input bit burst, input logic [2:0] hi, input logic [20:0] lo,
                      input string tag);
    logic [71:0] d;
    exp_t e;
    int k;
    @(negedge clk);
    d = rnd72();
    d[20:19] = tgt; d[25:21] = id; d[46:26] = lo;
    cmd_vld = 1; cmd_op = 2'b01; cmd_ext = {2'b00, hi, 3'b000, burst}; dq = d;
    k = cyc + 1;
    @(negedge clk);
    cmd_op = hold_b ? 2'b01 : 2'b10; dq = rnd72(); cmd_ext = 9'($urandom);
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      d = rnd72();
      d[20:19] = 2'b10; d[25:21] = MY_ID;
      cmd_vld = 1; cmd_op = 2'b01; cmd_ext = 9'($urandom) & 9'h1FE; dq = d;
    end
    if (hold_b && tgt == 2'b10 && id == MY_ID && !burst) begin
      e.due = k + 1 + LAT; e.adr = {hi, lo}; e.tag = tag;
      q.push_back(e);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cmd_vld = 0; cmd_op = 0; cmd_ext = 0; dq = rnd72();
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 0;
    idle(3);
    send(1, 2'b10, MY_ID, 0, 3'b101, 21'h1ABCDE, "R8_R6_basic");
    idle(12);
    send(0, 2'b10, MY_ID, 0, 3'b111, 21'h0F0F0F, "R2_drop_b");
    idle(12);
    send(1, 2'b01, MY_ID, 0, 3'b001, 21'h000111, "R3_bad_target");
    send(1, 2'b11, MY_ID, 0, 3'b001, 21'h000222, "R3_bad_target");
    send(1, 2'b10, 5'd8,  0, 3'b010, 21'h000333, "R4_bad_id");
    send(1, 2'b10, 5'd31, 0, 3'b010, 21'h000444, "R4_bad_id");
    send(1, 2'b10, MY_ID, 1, 3'b011, 21'h000555, "R5_burst");
    idle(12);
    send(1, 2'b10, MY_ID, 0, 3'b000, 21'h1FFFFF, "R6_adr_lo_ones");
    idle(9);
    send(1, 2'b10, MY_ID, 0, 3'b111, 21'h000000, "R6_adr_hi_ones");
    for (int i = 0; i < 6; i++)
      send(1, 2'b10, MY_ID, 0, 3'(i), 21'(32'h1000 * (i + 1) + i), "R10_b2b");
    send(1, 2'b10, 5'd3, 0, 3'b100, 21'h0ABCDE, "R4_mid_stream");
    send(1, 2'b10, MY_ID, 0, 3'b110, 21'h054321, "R10_after_reject");
    idle(LAT + 12);
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R10 pending writes act %0d exp 0", q.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog act hung exp done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule